// File: doc/BRIEF.md
# Extended-Range Programmable Integer Divider Chain

This block divides a fast clock by a programmable integer ratio and marks the end of every division cycle with a one-clock pulse. It is a cascade of divide-by-2/3 cells. Each cell passes a tick forward to the next cell and a swallow-enable signal back to the previous one. A cell whose program bit is set takes three input ticks instead of two, once per division cycle, so it adds its binary weight to the ratio.

A 2-bit length code picks how many cells take part: 5, 6, 7 or 8. A decoder holds the swallow-enable of the last active cell high through an OR gate. The cells above it are held in their start state, and a multiplexer takes the end-of-cycle tick from the last active cell. Each chain length covers one octave of ratios, so together the four lengths give every integer from 32 to 511 with no gap.

The program word and the length code are captured only when a division cycle ends, so every cycle runs with a single ratio. The whole chain runs on one clock: the tick that a cell passes on acts as a clock enable for the next cell, and does not drive a clock of its own.

Top module: `ext_mmd_divider`

## Requirements
- R1: With length code L (0..3), the active length is k = 5 + L cells, and the number of clocks between consecutive rising pulses is 2^k plus the sum of mod_word[i]*2^i for i from 0 to k-1. Bit i of mod_word belongs to cell i, and cell 0 is the cell nearest the clock.
- R2: Every integer ratio from 32 to 511 is reachable, each with exactly one length code (the one whose octave contains it).
- R3: div_pulse is high for exactly one clock per division cycle.
- R4: mod_word and len_sel are sampled only on the clock edge that ends a division cycle. A change made part-way through a cycle leaves that cycle's length unchanged. The cycle that follows the next pulse uses the new setting.
- R5: Bits of mod_word at positions k and above, where k is the active length, have no effect on the ratio.
- R6: Cells beyond the active length stay in their start state. After a switch to a longer chain, the first cycle therefore already has the exact new ratio.
- R7: While rst is high, div_pulse is low. After rst falls, the first cycle uses the shortest chain with an all-zero word, so the first pulse appears 32 clocks after release whatever the inputs are.
- R8: Consecutive pulses are never closer than 32 clocks or further apart than 511 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_word | input | 8 | Per-cell swallow program bits, bit i for cell i |
| len_sel | input | 2 | Chain length code; active length is 5 + len_sel cells |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |

## Verification
The end-of-cycle tick is registered, so each pulse appears one clock after the edge that closes its cycle. A setting written after a pulse is captured on the next closing edge, and it governs the interval from the pulse that follows to the one after that. The bench therefore changes inputs on the negative edge on which it sees a pulse, and checks each new setting one interval later, comparing a count of negative edges between pulses with the ratio formula. After reset release, the count runs from the release edge and must read 32. For the mid-cycle change, the edges waited before the change are added to the measured remainder, and the sum must equal the ratio in force before the change.

// File: rtl/mmd_pkg.sv
`timescale 1ns/1ps
package mmd_pkg;
   // Number of cells in the shortest selectable chain.
   function automatic int shortest_len(input int num_cells, input int len_bits);
      return num_cells - (1 << len_bits) + 1;
   endfunction

   // Cell count state: 0, 1 or 2 input ticks already taken in this output cycle.
   typedef logic [1:0] cell_cnt_t;
   localparam cell_cnt_t CNT_ZERO  = 2'd0;
   localparam cell_cnt_t CNT_PLAIN = 2'd1;
   localparam cell_cnt_t CNT_SWALW = 2'd2;
endpackage

// File: rtl/mmd_cell.sv
`timescale 1ns/1ps
module mmd_cell
   import mmd_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic en_in,
   input  logic prog_bit,
   input  logic mod_in,
   input  logic active,
   output logic tick_out,
   output logic mod_out,
   output logic busy
);
   cell_cnt_t cnt;
   cell_cnt_t last_cnt;
   logic      at_end;

   // Take an extra input tick once per cycle when programmed and enabled.
   assign last_cnt = (prog_bit && mod_in) ? CNT_SWALW : CNT_PLAIN;
   assign at_end   = (cnt == last_cnt);

   always_ff @(posedge clk) begin
      if (rst || !active)
         cnt <= CNT_ZERO;
      else if (en_in)
         cnt <= at_end ? CNT_ZERO : cnt + 2'd1;
   end

   assign tick_out = active && en_in && at_end;
   assign mod_out  = mod_in && at_end;
   assign busy     = (cnt != CNT_ZERO);
endmodule

// File: rtl/mmd_len_ctrl.sv
`timescale 1ns/1ps
module mmd_len_ctrl
   import mmd_pkg::*;
#(
   parameter int NUM_CELLS = 8,
   parameter int LEN_BITS  = 2,
   localparam int NUM_LEN   = 1 << LEN_BITS,
   localparam int MIN_CELLS = shortest_len(NUM_CELLS, LEN_BITS)
) (
   input  logic [LEN_BITS-1:0]  len_q,
   input  logic [NUM_LEN-1:0]   cand_tick,
   output logic [NUM_CELLS-1:0] force_mod,
   output logic [NUM_CELLS-1:0] active_mask,
   output logic                 end_tick
);
   // Decoder: the last active cell gets its swallow-enable forced high.
   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_dec
      if (i >= MIN_CELLS - 1 && i < NUM_CELLS - 1) begin : g_force
         assign force_mod[i] = (len_q == LEN_BITS'(i - MIN_CELLS + 1));
      end else begin : g_noforce
         assign force_mod[i] = 1'b0;
      end
      if (i < MIN_CELLS) begin : g_always_on
         assign active_mask[i] = 1'b1;
      end else begin : g_optional
         assign active_mask[i] = (len_q >= LEN_BITS'(i - MIN_CELLS + 1));
      end
   end

   // Multiplexer: the end-of-cycle tick comes from the last active cell.
   always_comb begin
      end_tick = 1'b0;
      for (int j = 0; j < NUM_LEN; j++)
         if (len_q == LEN_BITS'(j)) end_tick = cand_tick[j];
   end
endmodule

// File: rtl/ext_mmd_divider.sv
`timescale 1ns/1ps
module ext_mmd_divider
   import mmd_pkg::*;
#(
   parameter int NUM_CELLS = 8,
   parameter int LEN_BITS  = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_CELLS-1:0] mod_word,
   input  logic [LEN_BITS-1:0]  len_sel,
   output logic                 div_pulse
);
   localparam int NUM_LEN   = 1 << LEN_BITS;
   localparam int MIN_CELLS = shortest_len(NUM_CELLS, LEN_BITS);

   if (MIN_CELLS < 1) begin : g_bad_len
      $error("length code selects more lengths than there are cells");
   end
   if (NUM_CELLS > 24) begin : g_bad_cells
      $error("cell count out of supported range");
   end

   logic [NUM_CELLS-1:0] prog_q;
   logic [LEN_BITS-1:0]  len_q;
   logic [NUM_CELLS-1:0] cell_en;
   logic [NUM_CELLS-1:0] cell_tick;
   logic [NUM_CELLS-1:0] cell_mod_in;
   logic [NUM_CELLS-1:0] cell_mod_out;
   logic [NUM_CELLS-1:0] cell_busy;
   logic [NUM_CELLS-1:0] force_mod;
   logic [NUM_CELLS-1:0] active_mask;
   logic                 end_tick;

   // Forward tick path and backward swallow-enable path with OR forcing.
   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chain
      if (i == 0) begin : g_first
         assign cell_en[i] = 1'b1;
      end else begin : g_next
         assign cell_en[i] = cell_tick[i-1];
      end
      if (i == NUM_CELLS - 1) begin : g_top
         assign cell_mod_in[i] = 1'b1;
      end else if (i >= MIN_CELLS - 1) begin : g_or
         assign cell_mod_in[i] = cell_mod_out[i+1] | force_mod[i];
      end else begin : g_plain
         assign cell_mod_in[i] = cell_mod_out[i+1];
      end

      mmd_cell u_cell (
         .clk      (clk),
         .rst      (rst),
         .en_in    (cell_en[i]),
         .prog_bit (prog_q[i]),
         .mod_in   (cell_mod_in[i]),
         .active   (active_mask[i]),
         .tick_out (cell_tick[i]),
         .mod_out  (cell_mod_out[i]),
         .busy     (cell_busy[i])
      );
   end

   mmd_len_ctrl #(
      .NUM_CELLS (NUM_CELLS),
      .LEN_BITS  (LEN_BITS)
   ) u_len (
      .len_q       (len_q),
      .cand_tick   (cell_tick[NUM_CELLS-1:MIN_CELLS-1]),
      .force_mod   (force_mod),
      .active_mask (active_mask),
      .end_tick    (end_tick)
   );

   // Settings are taken only when a division cycle closes.
   always_ff @(posedge clk) begin
      if (rst) begin
         prog_q    <= '0;
         len_q     <= '0;
         div_pulse <= 1'b0;
      end else begin
         div_pulse <= end_tick;
         if (end_tick) begin
            prog_q <= mod_word;
            len_q  <= len_sel;
         end
      end
   end
endmodule

// File: rtl/ext_mmd_divider_chk.sv
`timescale 1ns/1ps
module ext_mmd_divider_chk
   import mmd_pkg::*;
#(
   parameter int NUM_CELLS = 8,
   parameter int LEN_BITS  = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 div_pulse,
   input logic                 end_tick,
   input logic                 mod_lo,
   input logic [LEN_BITS-1:0]  len_q,
   input logic [NUM_CELLS-1:0] prog_q,
   input logic [NUM_CELLS-1:0] cell_busy
);
   localparam int MIN_CELLS = shortest_len(NUM_CELLS, LEN_BITS);
   localparam int MIN_RATIO = 1 << MIN_CELLS;
   localparam int MAX_RATIO = (1 << (NUM_CELLS + 1)) - 1;
   localparam int GAP_W     = NUM_CELLS + 2;

   logic [GAP_W-1:0]     gap;
   logic [NUM_CELLS-1:0] expect_on;

   always_ff @(posedge clk) begin
      if (rst)
         gap <= '0;
      else if (div_pulse)
         gap <= GAP_W'(1);
      else if (gap != '1)
         gap <= gap + GAP_W'(1);
   end

   always_comb begin
      for (int i = 0; i < NUM_CELLS; i++)
         expect_on[i] = (i < MIN_CELLS) || (int'(len_q) >= i - MIN_CELLS + 1);
   end

   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
      div_pulse |=> !div_pulse);

   assert_gap_min_R8: assert property (@(posedge clk) disable iff (rst)
      div_pulse |-> (gap >= GAP_W'(MIN_RATIO)));

   assert_gap_max_R8: assert property (@(posedge clk) disable iff (rst)
      gap <= GAP_W'(MAX_RATIO));

   assert_hold_settings_R4: assert property (@(posedge clk) disable iff (rst)
      !end_tick |=> ($stable(len_q) && $stable(prog_q)));

   assert_idle_cells_R6: assert property (@(posedge clk) disable iff (rst)
      (cell_busy & ~expect_on) == '0);

   assert_end_aligned_R1: assert property (@(posedge clk) disable iff (rst)
      end_tick |-> mod_lo);

   assert_reset_quiet_R7: assert property (@(posedge clk)
      rst |=> !div_pulse);
endmodule

bind ext_mmd_divider ext_mmd_divider_chk #(
   .NUM_CELLS (NUM_CELLS),
   .LEN_BITS  (LEN_BITS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .div_pulse (div_pulse),
   .end_tick  (end_tick),
   .mod_lo    (cell_mod_out[0]),
   .len_q     (len_q),
   .prog_q    (prog_q),
   .cell_busy (cell_busy)
);

// File: tb/ext_mmd_divider_tb.sv
`timescale 1ns/1ps
module ext_mmd_divider_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] mod_word = 8'h00;
   logic [1:0] len_sel = 2'd0;
   logic       div_pulse;

   int checks = 0;
   int fails  = 0;

   ext_mmd_divider u_dut (
      .clk       (clk),
      .rst       (rst),
      .mod_word  (mod_word),
      .len_sel   (len_sel),
      .div_pulse (div_pulse)
   );

   always #2.5 clk = ~clk;

   // {ignored-bits flag, len_sel, mod_word, expected ratio}
   localparam int NVEC = 8;
   localparam logic [20:0] VECS [NVEC] = '{
      {1'b0, 2'd0, 8'h00, 10'd32},
      {1'b0, 2'd0, 8'h1F, 10'd63},
      {1'b1, 2'd0, 8'hE0, 10'd32},
      {1'b0, 2'd1, 8'h2A, 10'd106},
      {1'b0, 2'd2, 8'h55, 10'd213},
      {1'b0, 2'd3, 8'hFF, 10'd511},
      {1'b0, 2'd3, 8'h00, 10'd256},
      {1'b1, 2'd1, 8'hC1, 10'd65}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic next_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!div_pulse);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int n;
      int exp_prev;
      int lo;
      int hi;
      bit quiet;

      // R7: quiet during reset, first cycle 32 regardless of inputs
      mod_word = 8'hFF;
      len_sel  = 2'd3;
      quiet = 1'b1;
      repeat (5) begin
         @(negedge clk);
         if (div_pulse) quiet = 1'b0;
      end
      chk(quiet, "R7 pulse low in reset", int'(!quiet), 0);
      rst = 1'b0;
      next_pulse(n);
      chk(n == 32, "R7 first interval after reset", n, 32);
      next_pulse(n);
      chk(n == 511, "R1 interval with inputs loaded at first boundary", n, 511);

      // Vector table, pipelined: each interval reflects the setting applied one pulse earlier
      exp_prev = 0;
      for (int idx = 0; idx <= NVEC; idx++) begin
         if (idx < NVEC) begin
            len_sel  = VECS[idx][19:18];
            mod_word = VECS[idx][17:10];
         end
         next_pulse(n);
         if (idx > 0) begin
            chk(n == exp_prev, VECS[idx-1][20] ? "R5 ignored upper bits" : "R1 ratio formula",
                n, exp_prev);
         end
         if (idx < NVEC) exp_prev = int'(VECS[idx][9:0]);
      end

      // R2 / R6 / R8: sweep every ratio from 32 to 511
      lo = 1 << 30;
      hi = 0;
      for (int idx = 0; idx <= 480; idx++) begin
         if (idx < 480) begin
            int r;
            int k;
            r = 32 + idx;
            k = (r >= 256) ? 8 : (r >= 128) ? 7 : (r >= 64) ? 6 : 5;
            len_sel  = 2'(k - 5);
            mod_word = 8'(r - (1 << k));
         end
         next_pulse(n);
         if (idx > 0) begin
            int want;
            want = 32 + idx - 1;
            if (want == 64 || want == 128 || want == 256)
               chk(n == want, "R6 first cycle after lengthening", n, want);
            else
               chk(n == want, "R2 continuous range", n, want);
            if (n < lo) lo = n;
            if (n > hi) hi = n;
         end
      end
      chk(lo == 32, "R8 smallest gap", lo, 32);
      chk(hi == 511, "R8 largest gap", hi, 511);

      // R4: change mid-cycle does not alter the cycle in progress
      len_sel  = 2'd0;
      mod_word = 8'h05;
      next_pulse(n);
      @(negedge clk);
      chk(!div_pulse, "R3 pulse one clock wide", int'(div_pulse), 0);
      repeat (9) @(negedge clk);
      len_sel  = 2'd2;
      mod_word = 8'h10;
      next_pulse(n);
      chk(n + 10 == 37, "R4 cycle in progress keeps old ratio", n + 10, 37);
      next_pulse(n);
      chk(n == 144, "R4 new setting after next pulse", n, 144);

      // R7: reset in the middle of a cycle
      repeat (20) @(negedge clk);
      rst = 1'b1;
      quiet = 1'b1;
      repeat (3) begin
         @(negedge clk);
         if (div_pulse) quiet = 1'b0;
      end
      chk(quiet, "R7 pulse low in mid-run reset", int'(!quiet), 0);
      rst = 1'b0;
      next_pulse(n);
      chk(n == 32, "R7 first interval after mid-run reset", n, 32);
      next_pulse(n);
      chk(n == 144, "R1 held inputs reloaded after reset cycle", n, 144);

      finish_run();
   end
endmodule